// File: doc/BRIEF.md
# Banked Permuting Metric Store

This block forms the second stage of a parallel interleaver. It has several independent lanes. Each lane owns a bank that holds one slice of a block of soft metrics. On every accepted input cycle, each lane delivers one metric to its own bank. The bank writes that metric at a position taken from a preloaded per-lane address table. The metrics of a lane can therefore be placed in any order inside that lane. No metric ever moves to another lane.

When a bank slice has received a full block, its rows are presented in ascending row order, one row across all lanes per output transfer, under a ready handshake. Each lane keeps two halves of storage. A new block can be written into one half while the other half drains. Two complete address sets are held, one for interleaving and one for deinterleaving. A select input, sampled on the first write of each block, chooses which set that block uses. The tables are written one entry at a time, and only while the store holds no data.

Top module: `perm_store_banked`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid`, `block_done` and `overflow` are 0.
- R2: The k-th accepted input metric of lane l (k counted from 0 within a block) is stored at row T[set][l][k] of lane l's bank, where T is the address table. Output row r on lane l therefore carries the lane-l metric whose table entry equals r. Data never crosses lanes.
- R3: An `in_valid` cycle that finds both halves holding unread blocks is dropped. `overflow` is 1 in the following cycle, and the stored blocks are unchanged.
- R4: `block_done` is 1 for exactly one cycle, the cycle after the DEPTH-th accepted write of a block.
- R5: `out_valid` is 1 from the cycle after a block completes. Rows appear in order 0 to DEPTH-1, each lane on `out_data[l*WIDTH +: WIDTH]`. A row advances only on a cycle with `out_valid` and `out_ready` both high; otherwise the row is held stable.
- R6: A second block can be written while the first is still unread. Blocks are presented in the order they were written, and `out_valid` falls after the last row of the last block.
- R7: `dir_sel` is sampled on the first accepted write of a block (0 selects set 0, 1 selects set 1). Changes to `dir_sel` later in the same block have no effect.
- R8: A table write (`tbl_we` with `tbl_set`, `tbl_bank`, `tbl_idx`, `tbl_addr`) sets T[tbl_set][tbl_bank][tbl_idx] = tbl_addr only when no half holds data and no block is partly written. At any other time the write is ignored.
- R9: Cycles with `in_valid` low inside a block neither advance nor reset the write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One metric per lane is offered |
| in_data | input | LANES*WIDTH | Lane l metric at bits l*WIDTH +: WIDTH |
| dir_sel | input | 1 | Address set for the block, sampled on its first write |
| out_ready | input | 1 | Consumer accepts the current row |
| out_valid | output | 1 | A stored row is being presented |
| out_data | output | LANES*WIDTH | Current row, lane l at bits l*WIDTH +: WIDTH |
| block_done | output | 1 | One-cycle pulse after a block's last write |
| overflow | output | 1 | One-cycle pulse after a dropped input |
| tbl_we | input | 1 | Address table write strobe |
| tbl_set | input | 1 | Table set being written |
| tbl_bank | input | log2(LANES) | Lane whose table is written |
| tbl_idx | input | log2(DEPTH) | Arrival index being written |
| tbl_addr | input | log2(DEPTH) | Row assigned to that arrival index |

## Verification
The assertions check on every cycle that the completion pulse lasts one cycle and always coincides with a presented row. They also check that a presented row stays still while the consumer stalls, and that a drop never happens in the same cycle as a block completion. Only the bench scenarios can show that the permutation is correct: that each row holds the metric the table assigned to it, in both address sets. The bench scenarios also show that a mid-block change of the set select is ignored, that table writes made while data is stored have no effect, and that two queued blocks come out in order with a dropped input leaving them intact.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    typedef enum logic {
        SET_FWD = 1'b0,
        SET_INV = 1'b1
    } addr_set_e;

    localparam int NUM_SETS   = 2;
    localparam int NUM_HALVES = 2;

    function automatic logic other_half(input logic h);
        return ~h;
    endfunction

endpackage

// File: rtl/bperm_addr_table.sv
module bperm_addr_table
    import bperm_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  addr_set_e         ld_set,
    input  logic [LW-1:0]     ld_bank,
    input  logic [AW-1:0]     ld_idx,
    input  logic [AW-1:0]     ld_val,
    input  addr_set_e         rd_set,
    input  logic [AW-1:0]     rd_idx,
    output logic [LANES*AW-1:0] rd_addr
);

    logic [AW-1:0] tbl [NUM_SETS][LANES][DEPTH];

    // Identity mapping after reset; any later write replaces one entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int l = 0; l < LANES; l++) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        tbl[s][l][i] <= AW'(i);
                    end
                end
            end
        end else if (ld_en) begin
            tbl[ld_set][ld_bank][ld_idx] <= ld_val;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lookup
        assign rd_addr[l*AW +: AW] = tbl[rd_set][l][rd_idx];
    end

endmodule

// File: rtl/bperm_bank.sv
module bperm_bank
    import bperm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_half,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_half,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [NUM_HALVES][DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_half][wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_half][rd_addr];

endmodule

// File: rtl/bperm_ctrl.sv
module bperm_ctrl
    import bperm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          dir_sel,
    input  logic          out_ready,
    output logic          wr_en,
    output logic          wr_half,
    output logic [AW-1:0] wr_row,
    output addr_set_e     wr_set,
    output logic          rd_half,
    output logic [AW-1:0] rd_row,
    output logic          out_valid,
    output logic          block_done,
    output logic          overflow,
    output logic          idle
);

    localparam logic [AW-1:0] LAST_ROW = AW'(DEPTH - 1);

    logic [NUM_HALVES-1:0] full_q;
    logic                  wr_half_q;
    logic                  rd_half_q;
    logic [AW-1:0]         wr_cnt_q;
    logic [AW-1:0]         rd_cnt_q;
    addr_set_e             set_q;

    logic accept, drop, wr_last, rd_fire, rd_last;

    always_comb begin
        accept  = in_valid && !full_q[wr_half_q];
        drop    = in_valid &&  full_q[wr_half_q];
        wr_last = accept && (wr_cnt_q == LAST_ROW);
        rd_fire = full_q[rd_half_q] && out_ready;
        rd_last = rd_fire && (rd_cnt_q == LAST_ROW);
    end

    assign wr_en     = accept;
    assign wr_half   = wr_half_q;
    assign wr_row    = wr_cnt_q;
    assign wr_set    = (wr_cnt_q == '0) ? addr_set_e'(dir_sel) : set_q;
    assign rd_half   = rd_half_q;
    assign rd_row    = rd_cnt_q;
    assign out_valid = full_q[rd_half_q];
    assign idle      = (full_q == '0) && (wr_cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q     <= '0;
            wr_half_q  <= 1'b0;
            rd_half_q  <= 1'b0;
            wr_cnt_q   <= '0;
            rd_cnt_q   <= '0;
            set_q      <= SET_FWD;
            block_done <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            block_done <= wr_last;
            overflow   <= drop;
            if (accept) begin
                wr_cnt_q <= wr_last ? '0 : wr_cnt_q + 1'b1;
                if (wr_cnt_q == '0) begin
                    set_q <= addr_set_e'(dir_sel);
                end
            end
            if (wr_last) begin
                wr_half_q <= other_half(wr_half_q);
            end
            if (rd_fire) begin
                rd_cnt_q <= rd_last ? '0 : rd_cnt_q + 1'b1;
            end
            if (rd_last) begin
                rd_half_q <= other_half(rd_half_q);
            end
            for (int h = 0; h < NUM_HALVES; h++) begin
                if (wr_last && (wr_half_q == 1'(h))) begin
                    full_q[h] <= 1'b1;
                end else if (rd_last && (rd_half_q == 1'(h))) begin
                    full_q[h] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/perm_store_banked.sv
module perm_store_banked
    import bperm_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*WIDTH-1:0] in_data,
    input  logic                   dir_sel,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [LANES*WIDTH-1:0] out_data,
    output logic                   block_done,
    output logic                   overflow,
    input  logic                   tbl_we,
    input  logic                   tbl_set,
    input  logic [LW-1:0]          tbl_bank,
    input  logic [AW-1:0]          tbl_idx,
    input  logic [AW-1:0]          tbl_addr
);

    logic                wr_en;
    logic                wr_half;
    logic [AW-1:0]       wr_row;
    addr_set_e           wr_set;
    logic                rd_half;
    logic [AW-1:0]       rd_row;
    logic                idle;
    logic [LANES*AW-1:0] lane_addr;

    bperm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .dir_sel    (dir_sel),
        .out_ready  (out_ready),
        .wr_en      (wr_en),
        .wr_half    (wr_half),
        .wr_row     (wr_row),
        .wr_set     (wr_set),
        .rd_half    (rd_half),
        .rd_row     (rd_row),
        .out_valid  (out_valid),
        .block_done (block_done),
        .overflow   (overflow),
        .idle       (idle)
    );

    bperm_addr_table #(.LANES(LANES), .DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (tbl_we && idle),
        .ld_set  (addr_set_e'(tbl_set)),
        .ld_bank (tbl_bank),
        .ld_idx  (tbl_idx),
        .ld_val  (tbl_addr),
        .rd_set  (wr_set),
        .rd_idx  (wr_row),
        .rd_addr (lane_addr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        bperm_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
            .clk     (clk),
            .wr_en   (wr_en),
            .wr_half (wr_half),
            .wr_addr (lane_addr[l*AW +: AW]),
            .wr_data (in_data[l*WIDTH +: WIDTH]),
            .rd_half (rd_half),
            .rd_addr (rd_row),
            .rd_data (out_data[l*WIDTH +: WIDTH])
        );
    end

endmodule

// File: rtl/bperm_store_chk.sv
module bperm_store_chk #(
    parameter int LANES = 4,
    parameter int WIDTH = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   out_ready,
    input logic                   out_valid,
    input logic [LANES*WIDTH-1:0] out_data,
    input logic                   block_done,
    input logic                   overflow
);

    // R4: completion pulse lasts one cycle
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        block_done |=> !block_done);

    // R4, R5: a completed block is visible at once
    p_done_has_row_r4: assert property (@(posedge clk) disable iff (rst)
        block_done |-> out_valid);

    // R5: stalled row stays put
    p_hold_row_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3: a drop and a block completion are exclusive
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        !(overflow && block_done));

    // R3: a drop only follows an offered input while data was stored
    p_drop_cause_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> ($past(in_valid) && $past(out_valid)));

endmodule

bind perm_store_banked bperm_store_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .block_done (block_done),
    .overflow   (overflow)
);

// File: tb/perm_store_banked_test.sv
module perm_store_banked_test;

    localparam int L  = 4;
    localparam int D  = 8;
    localparam int W  = 8;
    localparam int AW = $clog2(D);
    localparam int LW = $clog2(L);

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic [L*W-1:0] in_data;
    logic           dir_sel;
    logic           out_ready;
    logic           out_valid;
    logic [L*W-1:0] out_data;
    logic           block_done;
    logic           overflow;
    logic           tbl_we;
    logic           tbl_set;
    logic [LW-1:0]  tbl_bank;
    logic [AW-1:0]  tbl_idx;
    logic [AW-1:0]  tbl_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    perm_store_banked #(.LANES(L), .DEPTH(D), .WIDTH(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .dir_sel(dir_sel), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .block_done(block_done), .overflow(overflow),
        .tbl_we(tbl_we), .tbl_set(tbl_set), .tbl_bank(tbl_bank),
        .tbl_idx(tbl_idx), .tbl_addr(tbl_addr)
    );

    function automatic int tb_tbl(int s, int l, int k);
        return (k * (3 + 2 * s) + l + 3 * s) % D;
    endfunction

    function automatic int tb_data(int b, int l, int k);
        return (b * 37 + l * 16 + k * 3) % 256;
    endfunction

    function automatic int tb_expect(int b, int s, int l, int r);
        for (int k = 0; k < D; k++) begin
            if (tb_tbl(s, l, k) == r) return tb_data(b, l, k);
        end
        return -1;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_entry(int s, int b, int k, int a);
        tbl_we   = 1'b1;
        tbl_set  = 1'(s);
        tbl_bank = LW'(b);
        tbl_idx  = AW'(k);
        tbl_addr = AW'(a);
        @(negedge clk);
        tbl_we   = 1'b0;
    endtask

    task automatic send_block(int b, int s, bit gaps);
        for (int k = 0; k < D; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            dir_sel  = (k == 0) ? 1'(s) : ~1'(s);   // R7: later flips ignored
            for (int l = 0; l < L; l++) in_data[l*W +: W] = W'(tb_data(b, l, k));
            if (gaps && (k % 2 == 1) && (k != D - 1)) begin
                @(negedge clk);
                in_valid = 1'b0;                     // R9: idle cycle
                in_data  = '1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 done pulse", int'(block_done), 1);
        check("R5 valid after block", int'(out_valid), 1);
        @(negedge clk);
        check("R4 done single", int'(block_done), 0);
    endtask

    task automatic drain_block(int b, int s, int stall_row);
        for (int r = 0; r < D; r++) begin
            check("R5 row valid", int'(out_valid), 1);
            for (int l = 0; l < L; l++)
                check("R2 permuted row", int'(out_data[l*W +: W]), tb_expect(b, s, l, r));
            if (r == stall_row) begin
                @(negedge clk);
                for (int l = 0; l < L; l++)
                    check("R5 stalled row", int'(out_data[l*W +: W]), tb_expect(b, s, l, r));
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_data = '0; dir_sel = 1'b0; out_ready = 1'b0;
        tbl_we = 1'b0; tbl_set = 1'b0; tbl_bank = '0; tbl_idx = '0; tbl_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 block_done", int'(block_done), 0);
        check("R1 overflow", int'(overflow), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after", int'(out_valid), 0);

        // R8: tables written while idle take effect
        for (int s = 0; s < 2; s++)
            for (int b = 0; b < L; b++)
                for (int k = 0; k < D; k++)
                    load_entry(s, b, k, tb_tbl(s, b, k));

        // R2, R5: set 0, contiguous input
        send_block(0, 0, 1'b0);
        drain_block(0, 0, -1);
        check("R6 empty after drain", int'(out_valid), 0);

        // R7, R9: set 1, gaps in input, stall during readout
        send_block(1, 1, 1'b1);
        drain_block(1, 1, 3);
        check("R6 empty after drain", int'(out_valid), 0);

        // R6: second block written while first unread
        send_block(2, 0, 1'b0);
        load_entry(0, 1, 0, tb_tbl(0, 1, 0) ^ 1);   // R8: must be ignored
        send_block(3, 0, 1'b1);

        // R3: both halves occupied, extra input dropped
        in_valid = 1'b1;
        in_data  = '1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 overflow pulse", int'(overflow), 1);
        check("R3 no completion", int'(block_done), 0);
        @(negedge clk);
        check("R3 overflow single", int'(overflow), 0);

        drain_block(2, 0, 5);
        drain_block(3, 0, -1);
        check("R6 empty after both", int'(out_valid), 0);
        check("R3 no stray overflow", int'(overflow), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule